// File: doc/BRIEF.md
# Four-Component Combined Tausworthe Random Word Generator

The block produces a stream of 32-bit pseudo-random words. Four independent 32-bit shift-register components run side by side. Each one has its own left-shift, right-shift, mask and feedback-shift constants. On every enabled clock all four advance together, and the output word is the XOR of the four freshly advanced states. Combining four differently tuned components gives a far longer period than any single shift register of the same width. The block suits noise, dither and test-pattern sources. It is not meant for cryptographic use.

After reset every component holds 12345 decimal. A 128-bit seed can be loaded at any time. Each 32-bit slice of the seed is checked against the smallest value its component needs to stay out of a degenerate state. A slice below that minimum is replaced by 12345. The output word is registered, and a valid flag marks the cycle that follows each step.

Top module: `tw_gen_top`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, rnd_o is 0 and valid_o is 0. All four component states hold 12345 decimal.
- R2: An enabled step advances each component k (k = 1..4) with b = ((z << A) ^ z) >> B and z' = ((z & M) << C) ^ b, in unsigned 32-bit arithmetic with truncation. The constants (A, B, M, C) are (6, 13, 0xFFFFFFFE, 18) for k=1, (2, 27, 0xFFFFFFF8, 2) for k=2, (13, 21, 0xFFFFFFF0, 7) for k=3 and (3, 12, 0xFFFFFF80, 13) for k=4. The next rnd_o is z1' ^ z2' ^ z3' ^ z4'.
- R3: With enable_i low and seed_load_i low, the states hold, rnd_o keeps its value and valid_o is 0. The next enabled step continues the sequence without skipping a value.
- R4: valid_o is 1 exactly in the cycle after an edge at which enable_i was 1 and seed_load_i was 0.
- R5: With seed_load_i high, the states load from seed_i at the next edge. Bits [31:0] go to component 1, [63:32] to component 2, [95:64] to component 3 and [127:96] to component 4. No step is taken.
- R6: During a load, any slice below its minimum is replaced by 12345 decimal. The minimums are 2 for component 1, 8 for component 2, 16 for component 3 and 128 for component 4. A slice equal to its minimum is kept.
- R7: When seed_load_i and enable_i are both high, the load wins. No step occurs, valid_o is 0 in the next cycle and rnd_o keeps its value.
- R8: Over 4000 consecutive enabled steps, every rnd_o word equals the recurrence of R2 started from the loaded seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Advance all components one step |
| seed_load_i | input | 1 | Load seed_i into the component states |
| seed_i | input | 128 | Seed, four 32-bit slices |
| rnd_o | output | 32 | Registered output word |
| valid_o | output | 1 | rnd_o was produced by the step at the previous edge |

## Verification
A seed load and a step request can arrive at the same edge. The bench raises seed_load_i and enable_i together after the stream is already running. It then checks that rnd_o is unchanged and valid_o is low in the next cycle. Next it checks that the first enabled step afterwards matches the reference recurrence started from the sanitised seed, not from the advanced one. Boundary seeds, both just under and exactly at each component minimum, are applied in the same way.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_COMP = 4;
  localparam int unsigned SEED_W   = WORD_W * NUM_COMP;
  localparam logic [WORD_W-1:0] DEFAULT_WORD = 32'd12345;

  typedef logic [WORD_W-1:0] word_t;

  function automatic int unsigned pre_shift(int unsigned idx);
    case (idx)
      0: return 6;
      1: return 2;
      2: return 13;
      default: return 3;
    endcase
  endfunction

  function automatic int unsigned post_shift(int unsigned idx);
    case (idx)
      0: return 13;
      1: return 27;
      2: return 21;
      default: return 12;
    endcase
  endfunction

  function automatic int unsigned fb_shift(int unsigned idx);
    case (idx)
      0: return 18;
      1: return 2;
      2: return 7;
      default: return 13;
    endcase
  endfunction

  // number of low state bits discarded by the mask
  function automatic int unsigned drop_bits(int unsigned idx);
    case (idx)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/tw_component.sv
module tw_component #(
  parameter int unsigned W       = 32,
  parameter int unsigned PRE_SH  = 6,
  parameter int unsigned POST_SH = 13,
  parameter int unsigned FB_SH   = 18,
  parameter int unsigned DROP    = 1
) (
  input  logic [W-1:0] z_i,
  output logic [W-1:0] z_o
);
  localparam logic [W-1:0] MASK = {W{1'b1}} << DROP;

  logic [W-1:0] mix;
  logic [W-1:0] fb;

  always_comb begin
    mix = ((z_i << PRE_SH) ^ z_i) >> POST_SH;
    fb  = (z_i & MASK) << FB_SH;
    z_o = fb ^ mix;
  end
endmodule

// File: rtl/tw_seed_fix.sv
module tw_seed_fix #(
  parameter int unsigned W    = 32,
  parameter int unsigned DROP = 1,
  parameter logic [W-1:0] DEF = 32'd12345
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  localparam logic [W-1:0] MIN_VAL = W'(1) << DROP;

  assign word_o = (word_i < MIN_VAL) ? DEF : word_i;
endmodule

// File: rtl/tw_gen_top.sv
module tw_gen_top
  import tw_pkg::*;
#(
  parameter int unsigned W = tw_pkg::WORD_W,
  parameter int unsigned N = tw_pkg::NUM_COMP
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           enable_i,
  input  logic           seed_load_i,
  input  logic [W*N-1:0] seed_i,
  output logic [W-1:0]   rnd_o,
  output logic           valid_o
);
  logic [N-1:0][W-1:0] state_q;
  logic [N-1:0][W-1:0] state_d;
  logic [N-1:0][W-1:0] stepped;
  logic [N-1:0][W-1:0] seed_ok;
  logic [W-1:0]        rnd_d;
  logic [W-1:0]        rnd_q;
  logic                valid_q;
  logic                do_step;

  for (genvar g = 0; g < N; g++) begin : g_comp
    tw_component #(
      .W       (W),
      .PRE_SH  (pre_shift(g)),
      .POST_SH (post_shift(g)),
      .FB_SH   (fb_shift(g)),
      .DROP    (drop_bits(g))
    ) u_comp (
      .z_i (state_q[g]),
      .z_o (stepped[g])
    );

    tw_seed_fix #(
      .W    (W),
      .DROP (drop_bits(g)),
      .DEF  (W'(DEFAULT_WORD))
    ) u_fix (
      .word_i (seed_i[g*W +: W]),
      .word_o (seed_ok[g])
    );
  end

  // load has priority over step
  assign do_step = enable_i & ~seed_load_i;

  always_comb begin
    rnd_d = '0;
    for (int k = 0; k < int'(N); k++) rnd_d ^= stepped[k];
    if (seed_load_i)  state_d = seed_ok;
    else if (do_step) state_d = stepped;
    else              state_d = state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= {N{W'(DEFAULT_WORD)}};
      rnd_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= do_step;
      if (do_step) rnd_q <= rnd_d;
    end
  end

  assign rnd_o   = rnd_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/tw_gen_chk.sv
module tw_gen_chk #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enable_i,
  input logic                seed_load_i,
  input logic [W-1:0]        rnd_o,
  input logic                valid_o,
  input logic [N-1:0][W-1:0] state_q
);
  // R1
  reset_out_chk: assert property (@(posedge clk_i) !rst_ni |-> (rnd_o == '0 && !valid_o));

  // R2
  xor_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rnd_o == (state_q[0] ^ state_q[1] ^ state_q[2] ^ state_q[3])));

  // R3
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(rnd_o));

  // R4
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(enable_i && !seed_load_i));

  // R4
  valid_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !seed_load_i) |=> valid_o);

  // R7
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> !valid_o);

  // R6
  min_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q[0] >= 2) && (state_q[1] >= 8) && (state_q[2] >= 16) && (state_q[3] >= 128));
endmodule

bind tw_gen_top tw_gen_chk #(.W(W), .N(N)) u_tw_gen_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .seed_load_i (seed_load_i),
  .rnd_o       (rnd_o),
  .valid_o     (valid_o),
  .state_q     (state_q)
);

// File: tb/tw_gen_top_tb_top.sv
module tw_gen_top_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         enable_i = 1'b0;
  logic         seed_load_i = 1'b0;
  logic [127:0] seed_i = '0;
  logic [31:0]  rnd_o;
  logic         valid_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mz [4];
  logic [31:0] last_rnd;

  always #4 clk_i = ~clk_i;

  tw_gen_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
    .seed_load_i(seed_load_i), .seed_i(seed_i),
    .rnd_o(rnd_o), .valid_o(valid_o)
  );

  function automatic logic [31:0] model_step();
    logic [31:0] b;
    b = ((mz[0] << 6) ^ mz[0]) >> 13;  mz[0] = ((mz[0] & 32'hFFFFFFFE) << 18) ^ b;
    b = ((mz[1] << 2) ^ mz[1]) >> 27;  mz[1] = ((mz[1] & 32'hFFFFFFF8) << 2) ^ b;
    b = ((mz[2] << 13) ^ mz[2]) >> 21; mz[2] = ((mz[2] & 32'hFFFFFFF0) << 7) ^ b;
    b = ((mz[3] << 3) ^ mz[3]) >> 12;  mz[3] = ((mz[3] & 32'hFFFFFF80) << 13) ^ b;
    return mz[0] ^ mz[1] ^ mz[2] ^ mz[3];
  endfunction

  function automatic logic [31:0] fix(logic [31:0] w, logic [31:0] lo);
    return (w < lo) ? 32'd12345 : w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(logic en, logic ld, logic [127:0] sd);
    enable_i = en; seed_load_i = ld; seed_i = sd;
    @(posedge clk_i); #1;
  endtask

  task automatic model_load(logic [127:0] sd);
    mz[0] = fix(sd[31:0], 32'd2);
    mz[1] = fix(sd[63:32], 32'd8);
    mz[2] = fix(sd[95:64], 32'd16);
    mz[3] = fix(sd[127:96], 32'd128);
  endtask

  task automatic t_reset();
    check("R1 rnd in reset", rnd_o, 32'h0);
    check("R1 valid in reset", {31'h0, valid_o}, 32'h0);
    rst_ni = 1'b1;
    cyc(1'b0, 1'b0, '0);
    check("R1 rnd after reset", rnd_o, 32'h0);
    check("R1 valid after reset", {31'h0, valid_o}, 32'h0);
    for (int k = 0; k < 4; k++) mz[k] = 32'd12345;
  endtask

  task automatic t_steps();
    for (int k = 0; k < 5; k++) begin
      cyc(1'b1, 1'b0, '0);
      check("R2 step from default", rnd_o, model_step());
      check("R4 valid after step", {31'h0, valid_o}, 32'h1);
    end
    last_rnd = rnd_o;
  endtask

  task automatic t_hold();
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b0, {4{32'hDEADBEEF}});
      check("R3 rnd held", rnd_o, last_rnd);
      check("R4 valid low idle", {31'h0, valid_o}, 32'h0);
    end
    cyc(1'b1, 1'b0, '0);
    check("R3 no skip after idle", rnd_o, model_step());
  endtask

  task automatic t_load();
    logic [127:0] sd = {32'h89ABCDEF, 32'h76543210, 32'h0F1E2D3C, 32'h12345678};
    cyc(1'b0, 1'b1, sd);
    check("R5 valid low after load", {31'h0, valid_o}, 32'h0);
    model_load(sd);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 1'b0, '0);
      check("R5 step from seed", rnd_o, model_step());
    end
  endtask

  task automatic t_fix();
    logic [127:0] sd = {32'd5, 32'd3, 32'd7, 32'd1};
    cyc(1'b0, 1'b1, sd);
    model_load(sd);
    cyc(1'b1, 1'b0, '0);
    check("R6 all below minimum", rnd_o, model_step());
    sd = {32'd127, 32'd16, 32'd8, 32'd2};
    cyc(1'b0, 1'b1, sd);
    model_load(sd);
    cyc(1'b1, 1'b0, '0);
    check("R6 at and under minimum", rnd_o, model_step());
  endtask

  task automatic t_collide();
    logic [127:0] sd = {32'hCAFEF00D, 32'h0000000F, 32'h00000008, 32'hA5A5A5A5};
    cyc(1'b1, 1'b0, '0);
    void'(model_step());
    last_rnd = rnd_o;
    cyc(1'b1, 1'b1, sd);
    check("R7 rnd held on load+enable", rnd_o, last_rnd);
    check("R7 valid low on load+enable", {31'h0, valid_o}, 32'h0);
    model_load(sd);
    cyc(1'b1, 1'b0, '0);
    check("R7 step from loaded seed", rnd_o, model_step());
  endtask

  task automatic t_long();
    logic [127:0] sd = {32'h13579BDF, 32'h2468ACE0, 32'hFEDCBA98, 32'h0BADC0DE};
    int bad0;
    cyc(1'b0, 1'b1, sd);
    model_load(sd);
    bad0 = n_bad;
    for (int k = 0; k < 4000; k++) begin
      cyc(1'b1, 1'b0, '0);
      if (n_bad - bad0 < 5) check("R8 long run", rnd_o, model_step());
      else void'(model_step());
    end
    check("R8 long run valid", {31'h0, valid_o}, 32'h1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20;
    t_reset();
    t_steps();
    t_hold();
    t_load();
    t_fix();
    t_collide();
    t_long();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule